// File: doc/BRIEF.md
# CAN Error Status Register

This block holds the error and status word of a CAN controller and raises its single error interrupt. A protocol engine outside the block reports bus error events and interrupt causes as single-cycle pulses. It also supplies the live state: warning levels, idle, transmit/receive activity and the two-bit fault confinement state. The block turns the pulses into sticky bits and presents them together with the live state in one 32-bit status word. Beside that word sits a control word that holds the interrupt enables.

Software reaches both words through a plain register port. Each word has a one-bit select, a read strobe and a write strobe. Read data is registered and appears the cycle after the read strobe. A read of the status word returns a snapshot and clears the six bus error bits. The interrupt cause bits stay set until software writes a one to them. When a new event arrives in the same cycle as a clearing access, the event wins and its bit stays set.

The block has no sequencing state. Its behaviour depends only on the register select, `SEL_STATUS` or `SEL_CTRL`, and on which strobe is asserted. The possible accesses are: idle, status read (snapshot plus clear), status write (write-one-to-clear), control read, and control write.

Top module: `can_err_stat_reg`

## Requirements
- R1: After reset every sticky bit and every enable is 0, `irq` is 0 and `rdata` is 0.
- R2: A pulse on `bus_err_ev[5:0]` sets the status bits 15..10 (index 5 = bit 15 recessive-bit error, 4 = bit 14 dominant-bit error, 3 = bit 13 acknowledge, 2 = bit 12 CRC, 1 = bit 11 form, 0 = bit 10 stuff). These bits hold until a status read.
- R3: A status read (`reg_sel`=0, `rd_en`=1) drives the pre-clear word on `rdata` the next cycle and clears bits 15..10. A control read clears nothing.
- R4: Any bus error pulse also sets the error interrupt bit 1.
- R5: A status write clears each of bits 17 (TX warning interrupt), 16 (RX warning interrupt), 2 (bus-off), 1 (error) and 0 (wake) whose written value is 1. Zeros have no effect, and the write leaves bits 15..10 unchanged.
- R6: The status word shows the live inputs with no storage. Bit 9 is the TX warning level, bit 8 the RX warning level, bit 7 idle and bit 6 transmit/receive activity. Bits 5:4 carry the fault confinement state (0 error-active, 1 error-passive, 2 or 3 bus-off). Bits 31..18 and 3 read 0.
- R7: An event pulse in the same cycle as a clearing read or write leaves its bit set.
- R8: The control word stores only the enables at bits 15 (bus-off), 14 (error), 11 (TX warning) and 10 (RX warning). All other control bits read 0.
- R9: `irq` is high exactly when a cause bit (17, 16, 2 or 1) is set together with its enable (11, 10, 15, 14 respectively). The wake bit never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the status word, 1 the control word |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bus_err_ev | input | 6 | Bus error event pulses |
| tx_warn_ev | input | 1 | TX warning interrupt event |
| rx_warn_ev | input | 1 | RX warning interrupt event |
| busoff_ev | input | 1 | Bus-off interrupt event |
| wake_ev | input | 1 | Wake-up event |
| tx_warn_lvl | input | 1 | Live TX warning level |
| rx_warn_lvl | input | 1 | Live RX warning level |
| bus_idle | input | 1 | Live bus idle |
| txrx_busy | input | 1 | Live transmit/receive activity |
| fault_conf | input | 2 | Live fault confinement state |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high together. They also assume that every input changes only between clock edges.

The bench drives every input on the falling edge and keeps the two strobes exclusive. It sweeps all 63 non-zero bus error patterns, all 64 live status combinations, and all 256 pairings of enable set and cause set. It also arranges same-cycle collisions of events with clearing reads and writes.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    localparam int WORD_W     = 32;
    localparam int BUS_ERR_N  = 6;
    localparam int CAUSE_N    = 5;   // twrn, rwrn, boff, err, wake
    localparam int MASK_N     = 4;   // boff, err, twrn, rwrn

    // status word positions
    localparam int POS_TWRN_INT = 17;
    localparam int POS_RWRN_INT = 16;
    localparam int POS_BUS_LO   = 10;
    localparam int POS_TX_LVL   = 9;
    localparam int POS_RX_LVL   = 8;
    localparam int POS_IDLE     = 7;
    localparam int POS_TXRX     = 6;
    localparam int POS_FC_LO    = 4;
    localparam int POS_BOFF_INT = 2;
    localparam int POS_ERR_INT  = 1;
    localparam int POS_WAK_INT  = 0;

    // control word positions
    localparam int POS_M_BOFF = 15;
    localparam int POS_M_ERR  = 14;
    localparam int POS_M_TWRN = 11;
    localparam int POS_M_RWRN = 10;

    // cause bank indices
    localparam int C_TWRN = 4;
    localparam int C_RWRN = 3;
    localparam int C_BOFF = 2;
    localparam int C_ERR  = 1;
    localparam int C_WAK  = 0;

    // mask bank indices
    localparam int M_BOFF = 3;
    localparam int M_ERR  = 2;
    localparam int M_TWRN = 1;
    localparam int M_RWRN = 0;

endpackage

// File: rtl/esr_sticky_bank.sv
module esr_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end

    // R7: an event always survives a coincident clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R2/R5: no bit drops without a clear request
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/esr_mask_reg.sv
module esr_mask_reg
    import can_esr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [MASK_N-1:0] mask_o,
    output logic [WORD_W-1:0] word_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_i) begin
            mask_o[M_BOFF] <= wdata_i[POS_M_BOFF];
            mask_o[M_ERR]  <= wdata_i[POS_M_ERR];
            mask_o[M_TWRN] <= wdata_i[POS_M_TWRN];
            mask_o[M_RWRN] <= wdata_i[POS_M_RWRN];
        end
    end

    always_comb begin
        word_o             = '0;
        word_o[POS_M_BOFF] = mask_o[M_BOFF];
        word_o[POS_M_ERR]  = mask_o[M_ERR];
        word_o[POS_M_TWRN] = mask_o[M_TWRN];
        word_o[POS_M_RWRN] = mask_o[M_RWRN];
    end

    // R8: masks only move on a control write
    p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/esr_irq_merge.sv
module esr_irq_merge
    import can_esr_pkg::*;
(
    input  logic [CAUSE_N-1:0] cause_i,
    input  logic [MASK_N-1:0]  mask_i,
    output logic               irq_o
);

    logic [MASK_N-1:0] hit;

    always_comb begin
        hit[M_BOFF] = cause_i[C_BOFF] & mask_i[M_BOFF];
        hit[M_ERR]  = cause_i[C_ERR]  & mask_i[M_ERR];
        hit[M_TWRN] = cause_i[C_TWRN] & mask_i[M_TWRN];
        hit[M_RWRN] = cause_i[C_RWRN] & mask_i[M_RWRN];
        irq_o       = |hit;
    end

endmodule

// File: rtl/can_err_stat_reg.sv
module can_err_stat_reg
    import can_esr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [5:0]  bus_err_ev,
    input  logic        tx_warn_ev,
    input  logic        rx_warn_ev,
    input  logic        busoff_ev,
    input  logic        wake_ev,
    input  logic        tx_warn_lvl,
    input  logic        rx_warn_lvl,
    input  logic        bus_idle,
    input  logic        txrx_busy,
    input  logic [1:0]  fault_conf,
    output logic        irq
);

    reg_sel_e           sel;
    logic               rd_status, wr_status, wr_ctrl;
    logic [BUS_ERR_N-1:0] bus_q, bus_clr;
    logic [CAUSE_N-1:0] cause_q, cause_set, cause_clr;
    logic [MASK_N-1:0]  mask_q;
    logic [WORD_W-1:0]  ctrl_word, status_word;

    assign sel       = reg_sel_e'(reg_sel);
    assign rd_status = rd_en && (sel == SEL_STATUS);
    assign wr_status = wr_en && (sel == SEL_STATUS);
    assign wr_ctrl   = wr_en && (sel == SEL_CTRL);

    assign bus_clr = {BUS_ERR_N{rd_status}};

    always_comb begin
        cause_set         = '0;
        cause_set[C_TWRN] = tx_warn_ev;
        cause_set[C_RWRN] = rx_warn_ev;
        cause_set[C_BOFF] = busoff_ev;
        cause_set[C_ERR]  = |bus_err_ev;
        cause_set[C_WAK]  = wake_ev;
        cause_clr         = '0;
        if (wr_status) begin
            cause_clr[C_TWRN] = wdata[POS_TWRN_INT];
            cause_clr[C_RWRN] = wdata[POS_RWRN_INT];
            cause_clr[C_BOFF] = wdata[POS_BOFF_INT];
            cause_clr[C_ERR]  = wdata[POS_ERR_INT];
            cause_clr[C_WAK]  = wdata[POS_WAK_INT];
        end
    end

    esr_sticky_bank #(.N(BUS_ERR_N)) u_bus_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (bus_err_ev),
        .clr_i (bus_clr),
        .q_o   (bus_q)
    );

    esr_sticky_bank #(.N(CAUSE_N)) u_cause_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cause_set),
        .clr_i (cause_clr),
        .q_o   (cause_q)
    );

    esr_mask_reg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (wdata),
        .mask_o  (mask_q),
        .word_o  (ctrl_word)
    );

    esr_irq_merge u_irq (
        .cause_i (cause_q),
        .mask_i  (mask_q),
        .irq_o   (irq)
    );

    always_comb begin
        status_word = '0;
        status_word[POS_TWRN_INT] = cause_q[C_TWRN];
        status_word[POS_RWRN_INT] = cause_q[C_RWRN];
        status_word[POS_BUS_LO +: BUS_ERR_N] = bus_q;
        status_word[POS_TX_LVL]   = tx_warn_lvl;
        status_word[POS_RX_LVL]   = rx_warn_lvl;
        status_word[POS_IDLE]     = bus_idle;
        status_word[POS_TXRX]     = txrx_busy;
        status_word[POS_FC_LO +: 2] = fault_conf;
        status_word[POS_BOFF_INT] = cause_q[C_BOFF];
        status_word[POS_ERR_INT]  = cause_q[C_ERR];
        status_word[POS_WAK_INT]  = cause_q[C_WAK];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (sel)
                SEL_STATUS: rdata <= status_word;
                SEL_CTRL:   rdata <= ctrl_word;
            endcase
        end
    end

    // R3: a status read with no new event leaves the bus bits empty
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && bus_err_ev == '0) |=> (bus_q == '0));

    // R4: any bus error raises the error cause
    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_ev != '0) |=> cause_q[C_ERR]);

    // R9: with every enable off the line is quiet
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R6: reserved status positions read zero
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_status) |-> (rdata[31:18] == '0 && rdata[3] == 1'b0));

endmodule

// File: tb/test_can_err_stat_reg.sv
module test_can_err_stat_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  bus_err_ev = '0;
    logic        tx_warn_ev = 0, rx_warn_ev = 0, busoff_ev = 0, wake_ev = 0;
    logic        tx_warn_lvl = 0, rx_warn_lvl = 0, bus_idle = 0, txrx_busy = 0;
    logic [1:0]  fault_conf = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_err_stat_reg i_can_err_stat_reg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .bus_err_ev(bus_err_ev),
        .tx_warn_ev(tx_warn_ev), .rx_warn_ev(rx_warn_ev), .busoff_ev(busoff_ev),
        .wake_ev(wake_ev), .tx_warn_lvl(tx_warn_lvl), .rx_warn_lvl(rx_warn_lvl),
        .bus_idle(bus_idle), .txrx_busy(txrx_busy), .fault_conf(fault_conf), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic sel, output logic [31:0] v);
        @(negedge clk); reg_sel = sel; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic do_write(input logic sel, input logic [31:0] d);
        @(negedge clk); reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] be, input logic tw, input logic rw,
                         input logic bo, input logic wk);
        @(negedge clk);
        bus_err_ev = be; tx_warn_ev = tw; rx_warn_ev = rw; busoff_ev = bo; wake_ev = wk;
        @(negedge clk);
        bus_err_ev = '0; tx_warn_ev = 0; rx_warn_ev = 0; busoff_ev = 0; wake_ev = 0;
    endtask

    task automatic clear_all();
        logic [31:0] v;
        do_write(1'b0, 32'h0003_0007);
        do_read(1'b0, v);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        do_read(1'b0, v); check("R1 status", v, 32'h0);
        do_read(1'b1, v); check("R1 ctrl", v, 32'h0);

        // R2 R3 R4 sweep of bus error patterns
        for (int p = 1; p < 64; p++) begin
            pulse(p[5:0], 0, 0, 0, 0);
            do_read(1'b0, v);
            check("R2 R4 bus bits", v, (32'(p) << 10) | 32'h2);
            do_read(1'b0, v);
            check("R3 cleared by read", v, 32'h2);
            do_write(1'b0, 32'h2);
        end

        // R3 control read does not clear
        pulse(6'h2A, 0, 0, 0, 0);
        do_read(1'b1, v);
        do_read(1'b0, v);
        check("R3 ctrl read no clear", v, 32'h0000_A802);
        clear_all();

        // R5 write-one-to-clear, zeros and bus bits unaffected
        pulse(6'h3F, 1, 1, 1, 1);
        do_write(1'b0, 32'h0);
        do_read(1'b1, v);
        pulse(6'h3F, 0, 0, 0, 0);
        do_write(1'b0, 32'h0000_0000);
        do_write(1'b0, 32'hFFFF_FFFF);
        do_read(1'b0, v);
        check("R5 w1c all", v, 32'h0000_FC00);
        clear_all();
        pulse(6'h0, 1, 1, 1, 1);
        do_write(1'b0, 32'h0001_0001);
        do_read(1'b0, v);
        check("R5 partial w1c", v, 32'h0002_0004);
        clear_all();

        // R6 live status sweep
        for (int k = 0; k < 64; k++) begin
            tx_warn_lvl = k[0]; rx_warn_lvl = k[1]; bus_idle = k[2];
            txrx_busy = k[3]; fault_conf = k[5:4];
            do_read(1'b0, v);
            exp = (32'(k[0]) << 9) | (32'(k[1]) << 8) | (32'(k[2]) << 7) |
                  (32'(k[3]) << 6) | (32'(k[5:4]) << 4);
            check("R6 live bits", v, exp);
        end
        tx_warn_lvl = 0; rx_warn_lvl = 0; bus_idle = 0; txrx_busy = 0; fault_conf = 0;

        // R7 event collides with clearing read
        @(negedge clk); reg_sel = 1'b0; rd_en = 1'b1; bus_err_ev = 6'h01;
        @(negedge clk); rd_en = 1'b0; bus_err_ev = '0; v = rdata;
        check("R7 snapshot before event", v, 32'h0);
        do_read(1'b0, v);
        check("R7 read collision kept", v, 32'h0000_0402);
        clear_all();
        // R7 event collides with write-one-to-clear
        @(negedge clk); reg_sel = 1'b0; wr_en = 1'b1; wdata = 32'h0000_0004; busoff_ev = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = '0; busoff_ev = 1'b0;
        do_read(1'b0, v);
        check("R7 write collision kept", v, 32'h0000_0004);
        clear_all();

        // R8 control word
        do_write(1'b1, 32'hFFFF_FFFF);
        do_read(1'b1, v);
        check("R8 ctrl readback", v, 32'h0000_CC00);
        do_write(1'b1, 32'h0000_4800);
        do_read(1'b1, v);
        check("R8 ctrl partial", v, 32'h0000_4800);

        // R9 enable x cause sweep; wake always pulsed
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 16; c++) begin
                do_write(1'b1, 32'h0);
                clear_all();
                // c: 0 twrn, 1 rwrn, 2 boff, 3 err ; m same order
                pulse(c[3] ? 6'h04 : 6'h00, c[0], c[1], c[2], 1'b1);
                do_write(1'b1, (32'(m[0]) << 11) | (32'(m[1]) << 10) |
                               (32'(m[2]) << 15) | (32'(m[3]) << 14));
                @(negedge clk);
                check("R9 irq", {31'h0, irq}, {31'h0, |(c[3:0] & m[3:0])});
            end
        end

        done = 1;
        finish_run();
    end

endmodule